// File: doc/BRIEF.md
# UART Modem Status and Interrupt Unit

This block holds the modem-control and modem-status registers of a 16550-style UART. It also produces the single interrupt line that the UART presents to its host. The CPU reaches it through a simple register port. That port has a 3-bit register index, a select, and one-cycle read and write strobes. It also has a divisor-access flag that hides the block's registers while the divisor latch is mapped in.

The clear-to-send pin is active low. It is brought into the clock domain by a synchronizer. Its asserted sense appears as a live status bit. Each change sets a sticky change flag, which a status read clears. The request-to-send pin is also active low. A control bit drives it, and the pin is forced inactive during reset and while loopback is selected.

The receiver, transmitter and FIFO logic live outside this block. They report to it through level flags:
- line error
- receive data available
- receive timeout
- transmit holding register empty
- FIFO mode
- automatic CTS flow control enabled

The block masks these flags with an enable register, ranks them, reports the highest-ranked one in an identification register, and drives a registered active-high interrupt.

Top module: `ums_modem_irq`

## Requirements
- R1: While `rst` is high and in the first cycle after, `rts_n` is 1 and `irq` is 0. The control, enable and change-flag state are all cleared, so reading index 4, index 1 and index 6 (with `cts_n` high) returns 0x00.
- R2: Index 4 is the modem control register, and it can be read and written. Only bit 1 (RTS request) and bit 4 (loopback) are stored. All other bits read as 0.
- R3: `rts_n` is 0 exactly when control bit 1 is 1 and control bit 4 is 0. In every other case it is 1. It is a register output that follows a control write at the second rising edge counted from the write edge.
- R4: Index 6 is the modem status register, and it is read-only. Bit 4 is the inverse of `cts_n` after a 2-stage synchronizer. Bit 3 is the change flag. The other bits read as 0.
- R5: Each level change of `cts_n` sets status bit 3 once. A read of index 6 clears it.
- R6: If a `cts_n` change reaches the edge detector in the same cycle as a status read, bit 3 remains set after that read.
- R7: Index 1 is the interrupt enable register. It stores bits 3:0 and its upper bits read as 0. The bits enable these sources:
  - bit 0: receive data available or timeout
  - bit 1: transmit holding register empty
  - bit 2: line error
  - bit 3: modem status change
- R8: `irq` is high in the cycle after any enabled source is pending. A modem status change counts as a source only while `auto_cts_en` is 0.
- R9: Index 2 is the interrupt identification register. Bits 3:0 hold the highest-priority pending source:
  - line error: 0110
  - data available: 0100
  - timeout: 1100, counted only when `fifo_mode` is 1
  - transmit empty: 0010
  - modem change: 0000
  - none: 0001

  Bits 7:6 read 11 when `fifo_mode` is 1.
- R10: The transmit-empty source becomes pending in two cases: on a rising edge of `thr_empty`, or when enable bit 1 is written from 0 to 1 while `thr_empty` is high. It is cleared by a read of index 2 that reports it, or by `thr_empty` going low.
- R11: When `dlab` is 1 or `sel` is 0, reads and writes have no effect on any register or flag, and the read data is 0x00.
- R12: `rd_data` is registered. It carries the addressed register in the cycle after the read strobe, and is 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| sel | input | 1 | Block select for register access |
| dlab | input | 1 | Divisor access flag; hides all registers when 1 |
| rd_en | input | 1 | One-cycle read strobe |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 3 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rx_err | input | 1 | Receiver line error pending |
| rx_avail | input | 1 | Receive data at or above trigger |
| rx_timeout | input | 1 | Receive character timeout |
| fifo_mode | input | 1 | FIFOs enabled |
| thr_empty | input | 1 | Transmit holding register empty |
| auto_cts_en | input | 1 | Automatic CTS flow control enabled |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq | output | 1 | Interrupt, active high |

## Verification
The hardest case to reach is a CTS change that lands in the detector in exactly the cycle of a status read (R6). The change must cross two synchronizer stages before the detector sees it. The bench therefore toggles `cts_n` on a falling edge and lets two rising edges pass. It then issues the status read so that the read's edge is the third one. The first read is expected to return the new level without the change flag. A second read must show the flag still set. The transmit-empty pending latch is also reached only through ordered steps: an enable write while the holding register is empty, an identification read that retires the source, and a fall of `thr_empty`.

// File: rtl/ums_pkg.sv
package ums_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] IDX_IER = 3'd1;
  localparam logic [AW-1:0] IDX_ISR = 3'd2;
  localparam logic [AW-1:0] IDX_MCR = 3'd4;
  localparam logic [AW-1:0] IDX_MSR = 3'd6;

  localparam int MCR_RTS_BIT  = 1;
  localparam int MCR_LOOP_BIT = 4;
  localparam int MSR_DCTS_BIT = 3;
  localparam int MSR_CTS_BIT  = 4;

  localparam int IE_RX    = 0;
  localparam int IE_THRE  = 1;
  localparam int IE_LINE  = 2;
  localparam int IE_MODEM = 3;
  localparam int IE_W     = 4;

  localparam logic [3:0] ID_LINE  = 4'b0110;
  localparam logic [3:0] ID_RXAV  = 4'b0100;
  localparam logic [3:0] ID_TOUT  = 4'b1100;
  localparam logic [3:0] ID_THRE  = 4'b0010;
  localparam logic [3:0] ID_MODEM = 4'b0000;
  localparam logic [3:0] ID_NONE  = 4'b0001;
endpackage

// File: rtl/ums_sync_edge.sv
module ums_sync_edge #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic chg
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RESET_VAL;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RESET_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[LAST-1];
  assign chg  = chain[LAST-1] ^ chain[LAST];
endmodule

// File: rtl/ums_irq_arb.sv
module ums_irq_arb
  import ums_pkg::*;
(
  input  logic [IE_W-1:0] ier,
  input  logic            line_src,
  input  logic            rxav_src,
  input  logic            tout_src,
  input  logic            thre_src,
  input  logic            modem_src,
  output logic [3:0]      id_code,
  output logic            any
);
  logic e_line, e_rxav, e_tout, e_thre, e_modem;

  always_comb begin
    e_line  = ier[IE_LINE]  & line_src;
    e_rxav  = ier[IE_RX]    & rxav_src;
    e_tout  = ier[IE_RX]    & tout_src;
    e_thre  = ier[IE_THRE]  & thre_src;
    e_modem = ier[IE_MODEM] & modem_src;
    any     = e_line | e_rxav | e_tout | e_thre | e_modem;
    if (e_line)       id_code = ID_LINE;
    else if (e_rxav)  id_code = ID_RXAV;
    else if (e_tout)  id_code = ID_TOUT;
    else if (e_thre)  id_code = ID_THRE;
    else if (e_modem) id_code = ID_MODEM;
    else              id_code = ID_NONE;
  end
endmodule

// File: rtl/ums_modem_irq.sv
module ums_modem_irq
  import ums_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          dlab,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rx_err,
  input  logic          rx_avail,
  input  logic          rx_timeout,
  input  logic          fifo_mode,
  input  logic          thr_empty,
  input  logic          auto_cts_en,
  input  logic          cts_n,
  output logic          rts_n,
  output logic          irq
);
  logic            acc_ok, rd_hit, wr_hit;
  logic            mcr_wr, ier_wr, msr_rd, isr_rd;
  logic            mcr_rts, mcr_loop;
  logic [IE_W-1:0] ier;
  logic            cts_sync_n, cts_chg, delta;
  logic            thr_q, thre_pend, thre_set, thre_clr;
  logic [3:0]      id_code;
  logic            irq_any;
  logic [DW-1:0]   mcr_val, msr_val, isr_val, ier_val, rd_mux;

  assign acc_ok = sel & ~dlab;
  assign rd_hit = acc_ok & rd_en;
  assign wr_hit = acc_ok & wr_en;
  assign mcr_wr = wr_hit & (addr == IDX_MCR);
  assign ier_wr = wr_hit & (addr == IDX_IER);
  assign msr_rd = rd_hit & (addr == IDX_MSR);
  assign isr_rd = rd_hit & (addr == IDX_ISR);

  ums_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts (
    .clk (clk),
    .rst (rst),
    .din (cts_n),
    .dout(cts_sync_n),
    .chg (cts_chg)
  );

  ums_irq_arb u_arb (
    .ier      (ier),
    .line_src (rx_err),
    .rxav_src (rx_avail),
    .tout_src (rx_timeout & fifo_mode),
    .thre_src (thre_pend),
    .modem_src(delta & ~auto_cts_en),
    .id_code  (id_code),
    .any      (irq_any)
  );

  assign thre_set = (thr_empty & ~thr_q)
                  | (ier_wr & wr_data[IE_THRE] & ~ier[IE_THRE] & thr_empty);
  assign thre_clr = ~thr_empty | (isr_rd & (id_code == ID_THRE));

  always_comb begin
    mcr_val = '0;
    mcr_val[MCR_RTS_BIT]  = mcr_rts;
    mcr_val[MCR_LOOP_BIT] = mcr_loop;
    msr_val = '0;
    msr_val[MSR_CTS_BIT]  = ~cts_sync_n;
    msr_val[MSR_DCTS_BIT] = delta;
    isr_val = {{2{fifo_mode}}, 2'b00, id_code};
    ier_val = {{(DW-IE_W){1'b0}}, ier};
    case (addr)
      IDX_IER: rd_mux = ier_val;
      IDX_ISR: rd_mux = isr_val;
      IDX_MCR: rd_mux = mcr_val;
      IDX_MSR: rd_mux = msr_val;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcr_rts   <= 1'b0;
      mcr_loop  <= 1'b0;
      ier       <= '0;
      delta     <= 1'b0;
      thr_q     <= 1'b0;
      thre_pend <= 1'b0;
      rts_n     <= 1'b1;
      irq       <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (mcr_wr) begin
        mcr_rts  <= wr_data[MCR_RTS_BIT];
        mcr_loop <= wr_data[MCR_LOOP_BIT];
      end
      if (ier_wr) ier <= wr_data[IE_W-1:0];
      delta <= (delta & ~msr_rd) | cts_chg;
      thr_q <= thr_empty;
      if (thre_set)      thre_pend <= 1'b1;
      else if (thre_clr) thre_pend <= 1'b0;
      rts_n   <= ~(mcr_rts & ~mcr_loop);
      irq     <= irq_any;
      rd_data <= rd_hit ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/ums_checker.sv
module ums_checker
  import ums_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            rts_n,
  input logic            irq,
  input logic            mcr_loop,
  input logic            delta,
  input logic            cts_chg,
  input logic            msr_rd,
  input logic [IE_W-1:0] ier,
  input logic            auto_cts_en,
  input logic            rx_err,
  input logic            rx_avail,
  input logic            rx_timeout
);
  assert_reset_outputs_R1: assert property (@(posedge clk)
    rst |=> (rts_n && !irq));

  assert_loop_forces_rts_R3: assert property (@(posedge clk) disable iff (rst)
    mcr_loop |=> rts_n);

  assert_change_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    cts_chg |=> delta);

  assert_read_clears_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && !cts_chg) |=> !delta);

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (delta && !msr_rd) |=> delta);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (ier == '0) |=> !irq);

  assert_auto_cts_blocks_modem_R8: assert property (@(posedge clk) disable iff (rst)
    (auto_cts_en && ier == 4'b1000) |=> !irq);

  assert_line_raises_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (ier[IE_LINE] && rx_err) |=> irq);

  assert_rx_raises_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (ier[IE_RX] && rx_avail && !rx_timeout) |=> irq);
endmodule

bind ums_modem_irq ums_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .rts_n      (rts_n),
  .irq        (irq),
  .mcr_loop   (mcr_loop),
  .delta      (delta),
  .cts_chg    (cts_chg),
  .msr_rd     (msr_rd),
  .ier        (ier),
  .auto_cts_en(auto_cts_en),
  .rx_err     (rx_err),
  .rx_avail   (rx_avail),
  .rx_timeout (rx_timeout)
);

// File: tb/ums_modem_irq_test.sv
module ums_modem_irq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, dlab = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rx_err = 0, rx_avail = 0, rx_timeout = 0, fifo_mode = 0;
  logic       thr_empty = 0, auto_cts_en = 0, cts_n = 1;
  logic       rts_n, irq;
  int         total = 0, bad = 0;
  logic [7:0] got;

  always #5 clk = ~clk;

  ums_modem_irq uut (
    .clk(clk), .rst(rst), .sel(sel), .dlab(dlab), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rx_err(rx_err),
    .rx_avail(rx_avail), .rx_timeout(rx_timeout), .fifo_mode(fifo_mode),
    .thr_empty(thr_empty), .auto_cts_en(auto_cts_en), .cts_n(cts_n),
    .rts_n(rts_n), .irq(irq)
  );

  // {ier[3:0], err, avail, tout, fifo, code[3:0], irq}
  localparam logic [12:0] VEC [8] = '{
    {4'hF, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0110, 1'b1},
    {4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0100, 1'b1},
    {4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1100, 1'b1},
    {4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b0},
    {4'hB, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0},
    {4'h4, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0110, 1'b1},
    {4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0100, 1'b1},
    {4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0001, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); #1;
    sel = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; rd_en = 1; addr = a;
    @(posedge clk); #1;
    d = rd_data;
    sel = 0; rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 rts_n in reset", {7'b0, rts_n}, 8'h01);
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    @(negedge clk); rst = 0;
    idle(1);
    rd(3'd4, got); check("R1 mcr after reset", got, 8'h00);
    rd(3'd1, got); check("R1 ier after reset", got, 8'h00);
    rd(3'd6, got); check("R1 msr after reset", got, 8'h00);
    check("R12 idle rd_data", rd_data, 8'h00);

    // Interrupt table (R7, R8, R9)
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, {4'h0, VEC[i][12:9]});
      @(negedge clk);
      rx_err = VEC[i][8]; rx_avail = VEC[i][7]; rx_timeout = VEC[i][6]; fifo_mode = VEC[i][5];
      idle(2);
      check("R8 irq vector", {7'b0, irq}, {7'b0, VEC[i][0]});
      rd(3'd2, got);
      check("R9 isr vector", got, {{2{VEC[i][5]}}, 2'b00, VEC[i][4:1]});
    end
    @(negedge clk); rx_err = 0; rx_avail = 0; rx_timeout = 0; fifo_mode = 0;
    wr(3'd1, 8'hFF);
    rd(3'd1, got); check("R7 ier upper bits", got, 8'h0F);
    wr(3'd1, 8'h00);

    // Control register and RTS (R2, R3)
    wr(3'd4, 8'h02); idle(1);
    check("R3 rts active", {7'b0, rts_n}, 8'h00);
    rd(3'd4, got); check("R2 mcr readback", got, 8'h02);
    wr(3'd4, 8'h12); idle(1);
    check("R3 loop forces rts high", {7'b0, rts_n}, 8'h01);
    wr(3'd4, 8'hFF);
    rd(3'd4, got); check("R2 mcr stored bits", got, 8'h12);
    wr(3'd4, 8'h00); idle(1);
    check("R3 rts cleared", {7'b0, rts_n}, 8'h01);

    // CTS status and change flag (R4, R5)
    @(negedge clk); cts_n = 0; idle(5);
    rd(3'd6, got); check("R4 R5 cts asserted with flag", got, 8'h18);
    rd(3'd6, got); check("R5 flag cleared by read", got, 8'h10);
    wr(3'd1, 8'h08);
    @(negedge clk); cts_n = 1; idle(5);
    check("R8 modem irq", {7'b0, irq}, 8'h01);
    rd(3'd2, got); check("R9 modem code", got, 8'h00);
    @(negedge clk); auto_cts_en = 1; idle(2);
    check("R8 auto cts masks modem irq", {7'b0, irq}, 8'h00);
    @(negedge clk); auto_cts_en = 0; idle(2);
    check("R8 modem irq back", {7'b0, irq}, 8'h01);
    rd(3'd6, got); check("R5 flag on release", got, 8'h08);
    idle(2);
    check("R8 irq serviced", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h00);

    // Change meeting a status read in the same cycle (R6)
    @(negedge clk); cts_n = 0;
    @(posedge clk); @(posedge clk);
    rd(3'd6, got); check("R6 read at change cycle", got, 8'h10);
    rd(3'd6, got); check("R6 flag kept", got, 8'h18);

    // Accesses ignored under divisor access or deselect (R11)
    @(negedge clk); cts_n = 1; idle(5);
    @(negedge clk); dlab = 1;
    wr(3'd4, 8'h02); idle(1);
    check("R11 rts unchanged under dlab", {7'b0, rts_n}, 8'h01);
    rd(3'd6, got); check("R11 read data zero under dlab", got, 8'h00);
    @(negedge clk); dlab = 0;
    @(negedge clk); rd_en = 1; addr = 3'd6; sel = 0;
    @(posedge clk); #1; check("R11 deselected read zero", rd_data, 8'h00);
    rd_en = 0;
    rd(3'd6, got); check("R11 flag survived ignored reads", got, 8'h08);
    rd(3'd4, got); check("R11 mcr not written", got, 8'h00);

    // Transmit-empty pending latch (R10)
    wr(3'd1, 8'h02);
    @(negedge clk); thr_empty = 1; idle(3);
    check("R10 thre rise raises irq", {7'b0, irq}, 8'h01);
    rd(3'd2, got); check("R10 thre code", got, 8'h02);
    idle(2);
    check("R10 isr read retires thre", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h02); idle(2);
    check("R10 enable while empty", {7'b0, irq}, 8'h01);
    @(negedge clk); thr_empty = 0; idle(2);
    check("R10 thr fill clears", {7'b0, irq}, 8'h00);

    // Reset mid-run (R1)
    wr(3'd4, 8'h02); idle(1);
    @(negedge clk); rst = 1; idle(1);
    check("R1 rts after late reset", {7'b0, rts_n}, 8'h01);
    @(negedge clk); rst = 0;
    rd(3'd4, got); check("R1 mcr after late reset", got, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule